// File: doc/BRIEF.md
# Refresh Debt Scheduler

This block tracks how many refresh operations a DRAM controller owes and turns that debt into refresh commands. A free-running timer adds one unit of debt every average refresh interval, which is set as a cycle count. While debt is outstanding the block raises a request towards the controller's command arbiter. A busy arbiter may defer refresh while traffic runs, up to a postponement limit. Once the debt reaches that limit the block also raises an urgent request, so the arbiter can force refresh in before the spacing between refreshes grows past one interval more than the limit.

A refresh goes out only when three conditions hold in the same cycle: the arbiter grants, every bank reports idle, and the block is not already in a hold-off. On the next cycle the block drives a one-cycle refresh strobe together with the refresh command code. It then keeps a busy signal high for the refresh cycle time, so that no other command is issued while the refresh completes. If the debt would pass its ceiling, a sticky error flag is set.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, req_o, urgent_o, ref_cmd_o, busy_o and overflow_o are 0 and cmd_o is the no-operation code 4'b0111.
- R2: The owed count starts at zero and rises by one every INTERVAL_CYC cycles. With no grant, req_o first goes high exactly INTERVAL_CYC cycles after the first clock edge with reset low.
- R3: req_o is high exactly when the owed count is nonzero and busy_o is low.
- R4: urgent_o is high exactly when the owed count is at least POSTPONE_MAX (8) and busy_o is low.
- R5: A refresh is accepted in a cycle where req_o, grant_i and banks_idle_i are all high. ref_cmd_o is then high for exactly the following cycle, and the owed count drops by one.
- R6: cmd_o, read as {chip select, row strobe, column strobe, write enable} with all of them active low, is 4'b0001 (refresh) in the strobe cycle and 4'b0111 (no operation) otherwise.
- R7: busy_o is high for exactly TRFC_CYC cycles, starting with the strobe cycle. No further refresh is accepted while it is high.
- R8: If an interval tick and an accepted refresh fall in the same cycle, the owed count is unchanged.
- R9: The owed count saturates at POSTPONE_MAX+1 (9). A tick that arrives at that value without a refresh in the same cycle sets overflow_o, and overflow_o then stays high until reset.
- R10: A grant while banks_idle_i is low issues nothing and leaves the owed count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Arbiter grants the command slot to refresh |
| banks_idle_i | input | 1 | All banks are precharged and idle |
| req_o | output | 1 | Refresh is owed and can be issued |
| urgent_o | output | 1 | Owed count at the postponement limit |
| ref_cmd_o | output | 1 | One-cycle refresh command strobe |
| cmd_o | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| busy_o | output | 1 | Refresh cycle time hold-off in progress |
| overflow_o | output | 1 | Sticky flag: owed count went past its ceiling |

## Verification
The bench lines a grant up with the exact cycle of an interval tick. A design that gives the tick or the decrement priority would then lose or gain one unit of debt, and the request would read differently once the hold-off ends. It also grants while the banks are busy, where a leaky design would emit a strobe or drain the debt. It leaves the grant low long enough for the debt to reach the urgent level, then reach its ceiling and overflow, catching an urgent flag that is off by one, a counter that wraps instead of saturating, or an error flag that clears itself. It also drains a backlog with the grant held high, where a hold-off that is one cycle short or long, or a request that is not masked during the hold-off, shows up as a misplaced or doubled strobe.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  // Command code bit order: {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] dram_cmd_t;
  localparam dram_cmd_t CMD_NOP     = 4'b0111;
  localparam dram_cmd_t CMD_REFRESH = 4'b0001;
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
  parameter int unsigned POSTPONE_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fire,
  output logic owed_nz,
  output logic owed_urgent,
  output logic overflow
);
  localparam int unsigned DEBT_MAX = POSTPONE_MAX + 1;
  localparam int unsigned DW       = $clog2(DEBT_MAX + 1);

  logic [DW-1:0] owed_q, owed_d;
  logic          ovf_q, ovf_d;
  logic          nz_q, urg_q;

  always_comb begin
    owed_d = owed_q;
    ovf_d  = ovf_q;
    case ({tick, fire})
      2'b10: begin
        if (owed_q == DW'(DEBT_MAX)) ovf_d  = 1'b1;
        else                         owed_d = owed_q + 1'b1;
      end
      2'b01:   owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
      ovf_q  <= 1'b0;
      nz_q   <= 1'b0;
      urg_q  <= 1'b0;
    end else begin
      owed_q <= owed_d;
      ovf_q  <= ovf_d;
      nz_q   <= (owed_d != '0);
      urg_q  <= (owed_d >= DW'(POSTPONE_MAX));
    end
  end

  assign owed_nz     = nz_q;
  assign owed_urgent = urg_q;
  assign overflow    = ovf_q;
endmodule

// File: rtl/refsched_hold.sv
module refsched_hold
  import refsched_pkg::*;
#(
  parameter int unsigned TRFC = 15
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fire,
  output logic      busy,
  output logic      strobe,
  output dram_cmd_t cmd
);
  localparam int unsigned HW = $clog2(TRFC + 1);

  logic [HW-1:0] hcnt_q;
  logic          strobe_q;
  dram_cmd_t     cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q   <= '0;
      strobe_q <= 1'b0;
      cmd_q    <= CMD_NOP;
    end else begin
      strobe_q <= fire;
      cmd_q    <= fire ? CMD_REFRESH : CMD_NOP;
      if (fire)              hcnt_q <= HW'(TRFC);
      else if (hcnt_q != '0) hcnt_q <= hcnt_q - 1'b1;
    end
  end

  assign busy   = (hcnt_q != '0);
  assign strobe = strobe_q;
  assign cmd    = cmd_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned TRFC_CYC     = 15,
  parameter int unsigned POSTPONE_MAX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       grant_i,
  input  logic       banks_idle_i,
  output logic       req_o,
  output logic       urgent_o,
  output logic       ref_cmd_o,
  output logic [3:0] cmd_o,
  output logic       busy_o,
  output logic       overflow_o
);
  logic      tick, fire, owed_nz, owed_urgent, busy;
  dram_cmd_t cmd;

  refsched_timer #(.PERIOD(INTERVAL_CYC)) timer_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  refsched_debt #(.POSTPONE_MAX(POSTPONE_MAX)) debt_i (
    .clk(clk), .rst(rst), .tick(tick), .fire(fire),
    .owed_nz(owed_nz), .owed_urgent(owed_urgent), .overflow(overflow_o)
  );

  refsched_hold #(.TRFC(TRFC_CYC)) hold_i (
    .clk(clk), .rst(rst), .fire(fire),
    .busy(busy), .strobe(ref_cmd_o), .cmd(cmd)
  );

  assign req_o    = owed_nz & ~busy;
  assign urgent_o = owed_urgent & ~busy;
  assign fire     = req_o & grant_i & banks_idle_i;
  assign busy_o   = busy;
  assign cmd_o    = cmd;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic       grant_i,
  input logic       banks_idle_i,
  input logic       req_o,
  input logic       urgent_o,
  input logic       ref_cmd_o,
  input logic [3:0] cmd_o,
  input logic       busy_o,
  input logic       overflow_o
);
  a_r5_needs_grant_idle: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> $past(grant_i && banks_idle_i && req_o));
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |=> !ref_cmd_o);
  a_r7_busy_on_strobe: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> busy_o);
  a_r7_no_issue_in_holdoff: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> !$past(busy_o));
  a_r3_req_masked_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_o);
  a_r4_urgent_implies_req: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> req_o);
  a_r6_refresh_code: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> (cmd_o == 4'b0001));
  a_r6_nop_code: assert property (@(posedge clk) disable iff (rst)
    !ref_cmd_o |-> (cmd_o == 4'b0111));
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);
endmodule

bind refresh_sched refresh_sched_chk chk_i (.*);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 20;
  localparam int TRFC       = 6;
  localparam int PMAX       = 8;

  logic clk = 1'b0;
  logic rst, grant_i, banks_idle_i;
  logic req_o, urgent_o, ref_cmd_o, busy_o, overflow_o;
  logic [3:0] cmd_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .POSTPONE_MAX(PMAX)) dut_i (
    .clk(clk), .rst(rst), .grant_i(grant_i), .banks_idle_i(banks_idle_i),
    .req_o(req_o), .urgent_o(urgent_o), .ref_cmd_o(ref_cmd_o), .cmd_o(cmd_o),
    .busy_o(busy_o), .overflow_o(overflow_o)
  );

  int n_chk = 0, n_fail = 0, n_strobe = 0, cyc = 0;
  // behavioural reference state: values valid during the current cycle
  int m_phase = 0, m_owed = 0, m_hold = 0;
  bit m_strobe = 0, m_ovf = 0;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    bit e_req, e_urg, fire, tick;
    cyc++;
    if (ref_cmd_o === 1'b1) n_strobe++;
    e_req = (m_owed > 0) && (m_hold == 0);
    e_urg = (m_owed >= PMAX) && (m_hold == 0);
    chk("R3 req_o", {3'b0, req_o}, {3'b0, e_req});
    chk("R4 urgent_o", {3'b0, urgent_o}, {3'b0, e_urg});
    chk("R5 ref_cmd_o", {3'b0, ref_cmd_o}, {3'b0, m_strobe});
    chk("R6 cmd_o", cmd_o, m_strobe ? 4'b0001 : 4'b0111);
    chk("R7 busy_o", {3'b0, busy_o}, {3'b0, m_hold > 0});
    chk("R9 overflow_o", {3'b0, overflow_o}, {3'b0, m_ovf});
    if (rst) begin
      m_phase = 0; m_owed = 0; m_hold = 0; m_strobe = 0; m_ovf = 0;
    end else begin
      fire = e_req && grant_i && banks_idle_i;
      tick = (m_phase == INTERVAL - 1);
      m_phase = tick ? 0 : m_phase + 1;
      if (tick && !fire) begin
        if (m_owed == PMAX + 1) m_ovf = 1;
        else m_owed++;
      end else if (fire && !tick) m_owed--;
      m_hold = fire ? TRFC : ((m_hold > 0) ? m_hold - 1 : 0);
      m_strobe = fire;
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    int s0;
    rst = 1'b1; grant_i = 1'b0; banks_idle_i = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 outputs", {req_o, urgent_o, ref_cmd_o, busy_o}, 4'b0000);
    chk("R1 overflow", {3'b0, overflow_o}, 4'b0);
    chk("R1 cmd", cmd_o, 4'b0111);
    @(posedge clk); #1 rst = 1'b0;
    // R2: first debt appears INTERVAL cycles after release
    repeat (INTERVAL) @(negedge clk);
    chk("R2 req before tick", {3'b0, req_o}, 4'b0);
    @(negedge clk);
    chk("R2 req after tick", {3'b0, req_o}, 4'b1);
    // steady refreshes with grant held high
    @(posedge clk); #1 grant_i = 1'b1;
    repeat (5 * INTERVAL) @(posedge clk);
    #1 grant_i = 1'b0;
    // R8: grant coincident with a tick while one refresh is owed
    forever begin
      @(posedge clk); #1;
      if (m_owed == 1 && m_phase == INTERVAL - 1 && m_hold == 0) break;
    end
    grant_i = 1'b1;
    @(posedge clk); #1 grant_i = 1'b0;
    repeat (TRFC + 1) @(negedge clk);
    chk("R8 debt kept after tick+issue", {3'b0, req_o}, 4'b1);
    // R10: grant without idle banks
    @(posedge clk); #1 grant_i = 1'b1; banks_idle_i = 1'b0;
    s0 = n_strobe;
    repeat (3 * INTERVAL) @(posedge clk);
    @(negedge clk);
    chk("R10 no strobe when banks busy", 4'(n_strobe - s0), 4'd0);
    chk("R10 debt still owed", {3'b0, req_o}, 4'b1);
    @(posedge clk); #1 grant_i = 1'b0; banks_idle_i = 1'b1;
    // R4: debt reaches the postponement limit
    forever begin
      @(posedge clk); #1;
      if (m_owed == PMAX) break;
    end
    @(negedge clk);
    chk("R4 urgent at limit", {3'b0, urgent_o}, 4'b1);
    // catch-up burst drains the debt
    @(posedge clk); #1 grant_i = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (m_owed == 0) break;
    end
    @(negedge clk);
    chk("R3 debt drained", {3'b0, req_o}, 4'b0);
    // R9: saturate and overflow
    @(posedge clk); #1 grant_i = 1'b0;
    repeat (11 * INTERVAL) @(posedge clk);
    @(negedge clk);
    chk("R9 overflow set", {3'b0, overflow_o}, 4'b1);
    chk("R9 still urgent", {3'b0, urgent_o}, 4'b1);
    finish_run();
  end
endmodule